// File: doc/BRIEF.md
# DMA Channel Manager Register Block

This block is the register file of a multi-channel memory access layer that feeds network DMA channels. A processor reaches it over a device-control-register bus: a single-cycle write strobe with a 10-bit register number and 32-bit data, and a read port that returns the addressed register combinationally. The block holds the global configuration, an error status word, the interrupt enable word, set and reset words for the transmit and receive channel-active controls, and four per-direction interrupt status words: end of buffer and descriptor error, for both transmit and receive. It also holds one descriptor table pointer per channel and one receive buffer size per receive channel. The descriptor fetch engine and the data movers are outside the block.

The fetch engine reports completions and descriptor faults through one event line per channel and per kind. Each event sets that channel's bit in the matching status word, and software clears the bits by writing ones. A configuration write with its top bit set acts as a soft reset. It returns the control words to their reset state and leaves the pointer and size tables untouched. The transmit and receive channel counts are parameters from 1 to 32. Per-channel register numbers above the configured counts do not respond.

Top module: `dma_chan_regs`

## Requirements
- R1: After the asynchronous reset, configuration reads 0x0007C000. Every other global register, every table pointer and every buffer size reads 0.
- R2: Register numbers 0x183, 0x188 to 0x18F, 0x194 to 0x19F, and every number outside the mapped set read as 0. Writes to them change no register.
- R3: A write to configuration (0x180) stores the data ANDed with 0x00FFC087, so bit 31 never reads back as 1.
- R4: A configuration write with data bit 31 set also clears, in the same cycle, error status (0x181), interrupt enable (0x182), the transmit active set/reset words (0x184/0x185), the receive active set/reset words (0x190/0x191), and the four interrupt status words (0x186, 0x187, 0x192, 0x193).
- R5: That soft reset leaves every table pointer and buffer size unchanged.
- R6: Interrupt enable keeps data bits 4:0. Transmit active set/reset keep bits 31:28. Receive active set/reset keep bits 31:30. Every other bit reads 0.
- R7: A write to error status or to an interrupt status word (transmit end-of-buffer 0x186, transmit descriptor error 0x187, receive end-of-buffer 0x192, receive descriptor error 0x193) clears exactly the bits written as 1.
- R8: An event on channel i sets bit 31-i of its status word one cycle later. This also happens in a cycle that carries a clear write or a soft reset to that word, so the set wins. Bits for channels at or above the count stay 0.
- R9: Transmit pointers sit at 0x1A0+i, receive pointers at 0x1C0+i and receive buffer sizes at 0x1E0+i. Pointers keep all 32 bits. Buffer sizes keep bits 7:0.
- R10: A per-channel register number whose index is at or above the transmit or receive count reads 0, and a write to it changes no table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dcr_wen | input | 1 | Write strobe, one write per cycle |
| dcr_addr | input | 10 | Register number for both read and write |
| dcr_wdata | input | 32 | Write data |
| dcr_rdata | output | 32 | Read data of the addressed register, combinational |
| tx_eob_evt | input | NTX | Transmit end-of-buffer event, one per channel |
| tx_derr_evt | input | NTX | Transmit descriptor error event, one per channel |
| rx_eob_evt | input | NRX | Receive end-of-buffer event, one per channel |
| rx_derr_evt | input | NRX | Receive descriptor error event, one per channel |

## Verification
The bench aims at the collision cases.

- An event arriving in the same cycle as a write-one-clear, or as a soft reset, must still leave its bit set. A design that ordered clear after set would drop the interrupt.
- A soft reset must clear every control word while the pointer tables survive. A design that cleared the tables would lose descriptor rings, and one that missed a word would leave a stale enable behind.
- Writes and reads at the first number past each channel count must not land in a table. Off-by-one window decoding would alias into the next table or corrupt a neighbour.
- Masked fields must drop their unkept bits. Channel-to-bit mapping must run from bit 31 downward, or status would appear on the wrong channel.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
  localparam int AW = 10;
  localparam int DW = 32;

  localparam logic [AW-1:0] A_CFG    = 10'h180;
  localparam logic [AW-1:0] A_ERR    = 10'h181;
  localparam logic [AW-1:0] A_IEN    = 10'h182;
  localparam logic [AW-1:0] A_TXSET  = 10'h184;
  localparam logic [AW-1:0] A_TXRST  = 10'h185;
  localparam logic [AW-1:0] A_TXEOB  = 10'h186;
  localparam logic [AW-1:0] A_TXDERR = 10'h187;
  localparam logic [AW-1:0] A_RXSET  = 10'h190;
  localparam logic [AW-1:0] A_RXRST  = 10'h191;
  localparam logic [AW-1:0] A_RXEOB  = 10'h192;
  localparam logic [AW-1:0] A_RXDERR = 10'h193;
  localparam logic [AW-1:0] A_TXPTR  = 10'h1A0;
  localparam logic [AW-1:0] A_RXPTR  = 10'h1C0;
  localparam logic [AW-1:0] A_RXBSZ  = 10'h1E0;

  localparam logic [DW-1:0] CFG_KEEP   = 32'h00FF_C087;
  localparam logic [DW-1:0] CFG_RSTVAL = 32'h0007_C000;
  localparam logic [DW-1:0] IEN_KEEP   = 32'h0000_001F;
  localparam logic [DW-1:0] TXACT_KEEP = 32'hF000_0000;
  localparam logic [DW-1:0] RXACT_KEEP = 32'hC000_0000;
  localparam logic [DW-1:0] BSZ_KEEP   = 32'h0000_00FF;
  localparam logic [DW-1:0] ALL_KEEP   = 32'hFFFF_FFFF;
  localparam int            SOFT_BIT   = 31;

  // Channel i owns bit 31-i; returns the bits owned by n channels.
  function automatic logic [DW-1:0] chan_bits(input int n);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < DW; i++) begin
      if (i < n) m[DW-1-i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/chan_evt_status.sv
module chan_evt_status
  import dmareg_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_en,
  input  logic [DW-1:0] clr_mask,
  input  logic          soft_clr,
  input  logic [NCH-1:0] evt,
  output logic [DW-1:0] stat
);
  localparam logic [DW-1:0] VALID = chan_bits(NCH);

  logic [DW-1:0] st_q, st_d, evt_bits;

  always_comb begin
    evt_bits = '0;
    for (int i = 0; i < NCH; i++) evt_bits[DW-1-i] = evt[i];
  end

  // Clear first, then merge events so a set in the same cycle survives.
  always_comb begin
    st_d = st_q;
    if (soft_clr)    st_d = '0;
    else if (clr_en) st_d = st_q & ~clr_mask;
    st_d = (st_d | evt_bits) & VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign stat = st_q;
endmodule

// File: rtl/chan_table.sv
module chan_table
  import dmareg_pkg::*;
#(
  parameter int            NCH  = 4,
  parameter logic [AW-1:0] BASE = 10'h1A0,
  parameter logic [DW-1:0] KEEP = 32'hFFFF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wen,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          hit,
  output logic [DW-1:0] rdata
);
  localparam logic [AW-1:0] LIMIT = AW'(NCH);

  logic [AW-1:0] idx;
  logic [DW-1:0] ent_q [NCH];

  assign idx = addr - BASE;
  assign hit = (addr >= BASE) && (idx < LIMIT);

  for (genvar g = 0; g < NCH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = wen && hit && (idx == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[g] <= '0;
      else if (ent_en) ent_q[g] <= wdata & KEEP;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (hit && idx == AW'(i)) rdata = ent_q[i];
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dmareg_pkg::*;
#(
  parameter int NTX = 4,
  parameter int NRX = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dcr_wen,
  input  logic [AW-1:0]  dcr_addr,
  input  logic [DW-1:0]  dcr_wdata,
  output logic [DW-1:0]  dcr_rdata,
  input  logic [NTX-1:0] tx_eob_evt,
  input  logic [NTX-1:0] tx_derr_evt,
  input  logic [NRX-1:0] rx_eob_evt,
  input  logic [NRX-1:0] rx_derr_evt
);
  logic wr_cfg, soft_rst;
  logic [DW-1:0] cfg_q, cfg_d, err_q, err_d, ier_q, ier_d;
  logic [DW-1:0] txset_q, txset_d, txrst_q, txrst_d;
  logic [DW-1:0] rxset_q, rxset_d, rxrst_q, rxrst_d;
  logic [DW-1:0] tx_eob_stat, tx_derr_stat, rx_eob_stat, rx_derr_stat;
  logic          txp_hit, rxp_hit, bsz_hit;
  logic [DW-1:0] txp_rd, rxp_rd, bsz_rd;
  logic [DW-1:0] glob_rd;

  assign wr_cfg   = dcr_wen && (dcr_addr == A_CFG);
  assign soft_rst = wr_cfg && dcr_wdata[SOFT_BIT];

  // Next state of the global control words
  always_comb begin
    cfg_d   = cfg_q;
    err_d   = err_q;
    ier_d   = ier_q;
    txset_d = txset_q;
    txrst_d = txrst_q;
    rxset_d = rxset_q;
    rxrst_d = rxrst_q;
    if (soft_rst) begin
      err_d   = '0;
      ier_d   = '0;
      txset_d = '0;
      txrst_d = '0;
      rxset_d = '0;
      rxrst_d = '0;
    end
    if (dcr_wen) begin
      unique case (dcr_addr)
        A_CFG:   cfg_d   = dcr_wdata & CFG_KEEP;
        A_ERR:   err_d   = err_q & ~dcr_wdata;
        A_IEN:   ier_d   = dcr_wdata & IEN_KEEP;
        A_TXSET: txset_d = dcr_wdata & TXACT_KEEP;
        A_TXRST: txrst_d = dcr_wdata & TXACT_KEEP;
        A_RXSET: rxset_d = dcr_wdata & RXACT_KEEP;
        A_RXRST: rxrst_d = dcr_wdata & RXACT_KEEP;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RSTVAL;
      err_q   <= '0;
      ier_q   <= '0;
      txset_q <= '0;
      txrst_q <= '0;
      rxset_q <= '0;
      rxrst_q <= '0;
    end else begin
      cfg_q   <= cfg_d;
      err_q   <= err_d;
      ier_q   <= ier_d;
      txset_q <= txset_d;
      txrst_q <= txrst_d;
      rxset_q <= rxset_d;
      rxrst_q <= rxrst_d;
    end
  end

  // Interrupt status words
  chan_evt_status #(.NCH(NTX)) u_tx_eob (
    .clk(clk), .rst_n(rst_n),
    .clr_en(dcr_wen && dcr_addr == A_TXEOB), .clr_mask(dcr_wdata),
    .soft_clr(soft_rst), .evt(tx_eob_evt), .stat(tx_eob_stat));

  chan_evt_status #(.NCH(NTX)) u_tx_derr (
    .clk(clk), .rst_n(rst_n),
    .clr_en(dcr_wen && dcr_addr == A_TXDERR), .clr_mask(dcr_wdata),
    .soft_clr(soft_rst), .evt(tx_derr_evt), .stat(tx_derr_stat));

  chan_evt_status #(.NCH(NRX)) u_rx_eob (
    .clk(clk), .rst_n(rst_n),
    .clr_en(dcr_wen && dcr_addr == A_RXEOB), .clr_mask(dcr_wdata),
    .soft_clr(soft_rst), .evt(rx_eob_evt), .stat(rx_eob_stat));

  chan_evt_status #(.NCH(NRX)) u_rx_derr (
    .clk(clk), .rst_n(rst_n),
    .clr_en(dcr_wen && dcr_addr == A_RXDERR), .clr_mask(dcr_wdata),
    .soft_clr(soft_rst), .evt(rx_derr_evt), .stat(rx_derr_stat));

  // Per-channel tables, untouched by the soft reset
  chan_table #(.NCH(NTX), .BASE(A_TXPTR), .KEEP(ALL_KEEP)) u_txptr (
    .clk(clk), .rst_n(rst_n), .wen(dcr_wen), .addr(dcr_addr),
    .wdata(dcr_wdata), .hit(txp_hit), .rdata(txp_rd));

  chan_table #(.NCH(NRX), .BASE(A_RXPTR), .KEEP(ALL_KEEP)) u_rxptr (
    .clk(clk), .rst_n(rst_n), .wen(dcr_wen), .addr(dcr_addr),
    .wdata(dcr_wdata), .hit(rxp_hit), .rdata(rxp_rd));

  chan_table #(.NCH(NRX), .BASE(A_RXBSZ), .KEEP(BSZ_KEEP)) u_rxbsz (
    .clk(clk), .rst_n(rst_n), .wen(dcr_wen), .addr(dcr_addr),
    .wdata(dcr_wdata), .hit(bsz_hit), .rdata(bsz_rd));

  // Read multiplexer
  always_comb begin
    unique case (dcr_addr)
      A_CFG:    glob_rd = cfg_q;
      A_ERR:    glob_rd = err_q;
      A_IEN:    glob_rd = ier_q;
      A_TXSET:  glob_rd = txset_q;
      A_TXRST:  glob_rd = txrst_q;
      A_TXEOB:  glob_rd = tx_eob_stat;
      A_TXDERR: glob_rd = tx_derr_stat;
      A_RXSET:  glob_rd = rxset_q;
      A_RXRST:  glob_rd = rxrst_q;
      A_RXEOB:  glob_rd = rx_eob_stat;
      A_RXDERR: glob_rd = rx_derr_stat;
      default:  glob_rd = '0;
    endcase
  end

  always_comb begin
    if (txp_hit)      dcr_rdata = txp_rd;
    else if (rxp_hit) dcr_rdata = rxp_rd;
    else if (bsz_hit) dcr_rdata = bsz_rd;
    else              dcr_rdata = glob_rd;
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
  import dmareg_pkg::*;
#(
  parameter int NTX = 4,
  parameter int NRX = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           dcr_wen,
  input logic [AW-1:0]  dcr_addr,
  input logic [DW-1:0]  dcr_wdata,
  input logic [DW-1:0]  dcr_rdata,
  input logic [NTX-1:0] tx_eob_evt,
  input logic [NRX-1:0] rx_derr_evt,
  input logic [DW-1:0]  cfg_q,
  input logic [DW-1:0]  ier_q,
  input logic [DW-1:0]  tx_eob_stat,
  input logic [DW-1:0]  rx_derr_stat
);
  a_r3_cfg_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (dcr_wen && dcr_addr == A_CFG) |=> (cfg_q == ($past(dcr_wdata) & CFG_KEEP)));

  a_r4_soft_clears_ien: assert property (@(posedge clk) disable iff (!rst_n)
    (dcr_wen && dcr_addr == A_CFG && dcr_wdata[SOFT_BIT]) |=> (ier_q == '0));

  a_r8_tx_eob_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_eob_evt[0] |=> tx_eob_stat[DW-1]);

  a_r8_rx_derr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_derr_evt[0] |=> rx_derr_stat[DW-1]);

  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (dcr_wen && dcr_addr == A_TXEOB && dcr_wdata[DW-1] && !tx_eob_evt[0])
      |=> !tx_eob_stat[DW-1]);

  a_r2_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dcr_addr == 10'h183) |-> (dcr_rdata == '0));

  if (NTX < 32) begin : g_txedge
    a_r10_tx_edge_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (dcr_addr == A_TXPTR + AW'(NTX)) |-> (dcr_rdata == '0));
  end
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NTX(NTX), .NRX(NRX)) u_chk (
  .clk(clk), .rst_n(rst_n), .dcr_wen(dcr_wen), .dcr_addr(dcr_addr),
  .dcr_wdata(dcr_wdata), .dcr_rdata(dcr_rdata), .tx_eob_evt(tx_eob_evt),
  .rx_derr_evt(rx_derr_evt), .cfg_q(cfg_q), .ier_q(ier_q),
  .tx_eob_stat(tx_eob_stat), .rx_derr_stat(rx_derr_stat));

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NTX = 4;
  localparam int NRX = 2;

  logic           clk, rst_n, wen;
  logic [9:0]     addr;
  logic [31:0]    wdata, rdata;
  logic [NTX-1:0] te, td;
  logic [NRX-1:0] re, rd;

  int total = 0, fails = 0;
  bit done = 0;

  dma_chan_regs #(.NTX(NTX), .NRX(NRX)) dut (
    .clk(clk), .rst_n(rst_n), .dcr_wen(wen), .dcr_addr(addr),
    .dcr_wdata(wdata), .dcr_rdata(rdata), .tx_eob_evt(te),
    .tx_derr_evt(td), .rx_eob_evt(re), .rx_derr_evt(rd));

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference state
  logic [31:0] m_cfg, m_err, m_ier, m_txs, m_txr, m_rxs, m_rxr;
  logic [31:0] m_teob, m_tde, m_reob, m_rde;
  logic [31:0] m_txp[NTX], m_rxp[NRX], m_bsz[NRX];

  function automatic logic [31:0] owned(int n);
    logic [31:0] m = 0;
    for (int i = 0; i < n; i++) m = m | (32'h8000_0000 >> i);
    return m;
  endfunction

  function automatic logic [31:0] spread(logic [31:0] ev, int n);
    logic [31:0] m = 0;
    for (int i = 0; i < n; i++) if (ev[i]) m = m | (32'h8000_0000 >> i);
    return m;
  endfunction

  function automatic logic [31:0] model_read(logic [9:0] a);
    for (int i = 0; i < NTX; i++) if (a == 10'h1A0 + 10'(i)) return m_txp[i];
    for (int i = 0; i < NRX; i++) if (a == 10'h1C0 + 10'(i)) return m_rxp[i];
    for (int i = 0; i < NRX; i++) if (a == 10'h1E0 + 10'(i)) return m_bsz[i];
    case (a)
      10'h180: return m_cfg;   10'h181: return m_err;
      10'h182: return m_ier;   10'h184: return m_txs;
      10'h185: return m_txr;   10'h186: return m_teob;
      10'h187: return m_tde;   10'h190: return m_rxs;
      10'h191: return m_rxr;   10'h192: return m_reob;
      10'h193: return m_rde;   default: return 0;
    endcase
  endfunction

  function automatic string req_of(logic [9:0] a);
    if (a >= 10'h1A0) begin
      if ((a >= 10'h1A0 && a < 10'h1A0 + NTX) || (a >= 10'h1C0 && a < 10'h1C0 + NRX) ||
          (a >= 10'h1E0 && a < 10'h1E0 + NRX)) return "R9";
      return "R10";
    end
    case (a)
      10'h180: return "R3";
      10'h182, 10'h184, 10'h185, 10'h190, 10'h191: return "R6";
      10'h181, 10'h186, 10'h187, 10'h192, 10'h193: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic model_reset();
    m_cfg = 32'h0007_C000;
    {m_err, m_ier, m_txs, m_txr, m_rxs, m_rxr} = '0;
    {m_teob, m_tde, m_reob, m_rde} = '0;
    for (int i = 0; i < NTX; i++) m_txp[i] = 0;
    for (int i = 0; i < NRX; i++) begin m_rxp[i] = 0; m_bsz[i] = 0; end
  endtask

  task automatic model_step(bit w, logic [9:0] a, logic [31:0] d,
                            logic [31:0] ev_te, ev_td, ev_re, ev_rd);
    if (w && a == 10'h180 && d[31]) begin
      {m_err, m_ier, m_txs, m_txr, m_rxs, m_rxr} = '0;
      {m_teob, m_tde, m_reob, m_rde} = '0;
    end
    if (w) begin
      case (a)
        10'h180: m_cfg = d & 32'h00FF_C087;
        10'h181: m_err = m_err & ~d;
        10'h182: m_ier = d & 32'h1F;
        10'h184: m_txs = d & 32'hF000_0000;
        10'h185: m_txr = d & 32'hF000_0000;
        10'h186: m_teob = m_teob & ~d;
        10'h187: m_tde = m_tde & ~d;
        10'h190: m_rxs = d & 32'hC000_0000;
        10'h191: m_rxr = d & 32'hC000_0000;
        10'h192: m_reob = m_reob & ~d;
        10'h193: m_rde = m_rde & ~d;
        default: ;
      endcase
      for (int i = 0; i < NTX; i++) if (a == 10'h1A0 + 10'(i)) m_txp[i] = d;
      for (int i = 0; i < NRX; i++) if (a == 10'h1C0 + 10'(i)) m_rxp[i] = d;
      for (int i = 0; i < NRX; i++) if (a == 10'h1E0 + 10'(i)) m_bsz[i] = d & 32'hFF;
    end
    m_teob = (m_teob | spread(ev_te, NTX)) & owned(NTX);
    m_tde  = (m_tde  | spread(ev_td, NTX)) & owned(NTX);
    m_reob = (m_reob | spread(ev_re, NRX)) & owned(NRX);
    m_rde  = (m_rde  | spread(ev_rd, NRX)) & owned(NRX);
  endtask

  task automatic check(string tag, logic [9:0] a, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, act, exp);
    end
  endtask

  // One bus cycle: drive, compare the read of the pre-edge state, advance the model.
  task automatic cyc(bit w, logic [9:0] a, logic [31:0] d, logic [31:0] ev_te,
                     logic [31:0] ev_td, logic [31:0] ev_re, logic [31:0] ev_rd, string tag);
    @(negedge clk);
    wen = w; addr = a; wdata = d;
    te = ev_te[NTX-1:0]; td = ev_td[NTX-1:0];
    re = ev_re[NRX-1:0]; rd = ev_rd[NRX-1:0];
    #1;
    check(tag, a, rdata, model_read(a));
    @(posedge clk);
    model_step(w, a, d, ev_te & owned32(NTX), ev_td & owned32(NTX),
               ev_re & owned32(NRX), ev_rd & owned32(NRX));
  endtask

  function automatic logic [31:0] owned32(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
  endfunction

  task automatic wr(logic [9:0] a, logic [31:0] d, string tag);
    cyc(1, a, d, 0, 0, 0, 0, tag);
  endtask
  task automatic rdc(logic [9:0] a, string tag);
    cyc(0, a, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wen = 0; addr = 0; wdata = 0; te = 0; td = 0; re = 0; rd = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: reset state of every register
    for (int a = 10'h180; a <= 10'h194; a++) rdc(10'(a), "R1");
    for (int i = 0; i < NTX; i++) rdc(10'h1A0 + 10'(i), "R1");
    for (int i = 0; i < NRX; i++) begin rdc(10'h1C0 + 10'(i), "R1"); rdc(10'h1E0 + 10'(i), "R1"); end

    // R6: field masks
    wr(10'h182, 32'hFFFF_FFFF, "R6"); rdc(10'h182, "R6");
    wr(10'h184, 32'hFFFF_FFFF, "R6"); rdc(10'h184, "R6");
    wr(10'h185, 32'hA5A5_A5A5, "R6"); rdc(10'h185, "R6");
    wr(10'h190, 32'hFFFF_FFFF, "R6"); rdc(10'h190, "R6");
    wr(10'h191, 32'h7FFF_FFFF, "R6"); rdc(10'h191, "R6");

    // R9: tables
    for (int i = 0; i < NTX; i++) wr(10'h1A0 + 10'(i), 32'hC0DE_0000 + i, "R9");
    for (int i = 0; i < NRX; i++) begin
      wr(10'h1C0 + 10'(i), 32'hBEEF_1000 + i, "R9");
      wr(10'h1E0 + 10'(i), 32'h1234_5670 + i, "R9");
    end
    for (int i = 0; i < NTX; i++) rdc(10'h1A0 + 10'(i), "R9");
    for (int i = 0; i < NRX; i++) begin rdc(10'h1C0 + 10'(i), "R9"); rdc(10'h1E0 + 10'(i), "R9"); end

    // R10: first index past each count
    wr(10'h1A0 + NTX, 32'hDEAD_BEEF, "R10"); rdc(10'h1A0 + NTX, "R10");
    wr(10'h1C0 + NRX, 32'hDEAD_BEEF, "R10"); rdc(10'h1C0 + NRX, "R10");
    wr(10'h1E0 + NRX, 32'hDEAD_BEEF, "R10"); rdc(10'h1E0 + NRX, "R10");
    rdc(10'h1A0 + NTX - 1, "R10"); rdc(10'h1C0 + NRX - 1, "R10"); rdc(10'h1E0 + NRX - 1, "R10");

    // R2: holes
    wr(10'h183, 32'hFFFF_FFFF, "R2"); rdc(10'h183, "R2");
    wr(10'h18F, 32'hFFFF_FFFF, "R2"); rdc(10'h18F, "R2"); rdc(10'h182, "R2");

    // R8: events, channel i -> bit 31-i
    cyc(0, 10'h186, 0, 32'h9, 32'h2, 32'h1, 32'h2, "R8");
    rdc(10'h186, "R8"); rdc(10'h187, "R8"); rdc(10'h192, "R8"); rdc(10'h193, "R8");

    // R7: write-one-clear, zeros keep bits
    wr(10'h186, 32'h8000_0000, "R7"); rdc(10'h186, "R7");
    wr(10'h186, 32'h0, "R7"); rdc(10'h186, "R7");
    wr(10'h193, 32'hFFFF_FFFF, "R7"); rdc(10'h193, "R7");

    // R8: set wins against a clear in the same cycle
    cyc(1, 10'h186, 32'hFFFF_FFFF, 32'h2, 0, 0, 0, "R8"); rdc(10'h186, "R8");

    // R3: configuration mask
    wr(10'h180, 32'h7FFF_FFFF, "R3"); rdc(10'h180, "R3");

    // R4/R5/R8: soft reset with a concurrent receive event
    wr(10'h182, 32'h1F, "R4");
    cyc(0, 10'h187, 0, 0, 32'h4, 0, 0, "R4");
    cyc(1, 10'h180, 32'h8000_0001, 0, 0, 32'h1, 0, "R4");
    for (int a = 10'h180; a <= 10'h193; a++) rdc(10'(a), "R4");
    rdc(10'h192, "R8");
    for (int i = 0; i < NTX; i++) rdc(10'h1A0 + 10'(i), "R5");
    for (int i = 0; i < NRX; i++) begin rdc(10'h1C0 + 10'(i), "R5"); rdc(10'h1E0 + 10'(i), "R5"); end

    // Mixed traffic compared every cycle
    for (int n = 0; n < 4000; n++) begin
      logic [9:0] a;
      int k = $urandom_range(0, 5);
      case (k)
        0: a = 10'h180 + 10'($urandom_range(0, 7));
        1: a = 10'h190 + 10'($urandom_range(0, 4));
        2: a = 10'h1A0 + 10'($urandom_range(0, NTX));
        3: a = 10'h1C0 + 10'($urandom_range(0, NRX));
        4: a = 10'h1E0 + 10'($urandom_range(0, NRX));
        default: a = 10'($urandom);
      endcase
      cyc($urandom_range(0, 1) == 1, a,
          ($urandom_range(0, 15) == 0) ? $urandom : ($urandom & 32'h7FFF_FFFF),
          $urandom & $urandom & $urandom, $urandom & $urandom & $urandom,
          $urandom & $urandom & $urandom, $urandom & $urandom & $urandom, req_of(a));
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule